// File: doc/BRIEF.md
# Three-Tone Digital IQ Demodulator

This block takes the samples of one ADC that carries three intermediate frequencies, combined in analog ahead of the converter. It recovers a complex baseband value, I and Q, for each of the three. With a sample clock of 1300/32 MHz, the tones sit at 1300/144, 1300/96 and 1300/72 MHz. These are exactly 2/9, 3/9 and 4/9 cycles per sample, so any 9 consecutive samples hold a whole number of cycles of every tone. Over such a window the three tones are orthogonal. The block multiplies each sample by a per-tone cosine and sine taken from fixed tables and sums the products over the window. It scales each sum by 2/9 and presents six results with a one-cycle strobe.

The three outputs carry the cavity pick-up (lowest tone), the cavity forward drive (middle tone) and the cavity reflection (highest tone). One instance serves one ADC channel, so ten converters give thirty signals. A timing strobe restarts the 9-sample window, which keeps the I/Q phase reference common across channels.

Top module: `multi_if_iq_demod`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `valid` is 0 and all six outputs read 0.
- R2: With `align` held low, `valid` is high for exactly one cycle in every 9. The window is the 9 samples consumed before that cycle.
- R3: The sample that is presented in the cycle after `align` is high takes window index n=0. The result of the window that starts there appears with `valid` 9 cycles after that sample. No sample from before `align` contributes to it.
- R4: For an input x[n] = A·cos(2π·2n/9 + φ), `pu_i` ≈ A·cos φ and `pu_q` ≈ A·sin φ, within 6 LSB. In general I = (2/9)·Σx[n]·cos(2πkn/9) and Q = −(2/9)·Σx[n]·sin(2πkn/9).
- R5: The same relation holds for the 3/9 tone (k=3) on `fw_i`/`fw_q`.
- R6: The same relation holds for the 4/9 tone (k=4) on `rf_i`/`rf_q`.
- R7: A pure tone at one frequency gives outputs within 6 LSB of 0 on the other two pairs.
- R8: The six outputs change only in the cycle in which `valid` is high, and hold their values between strobes.
- R9: For any 16-bit input, each output's magnitude stays within 2^(OUT_W-2). A full-scale tone is reported without wrap.
- R10: A sum of all three tones is separated, and each pair matches its own tone within 6 LSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| align | input | 1 | Timing strobe; restarts the 9-sample window |
| adc | input | DATA_W | Signed ADC sample |
| valid | output | 1 | One-cycle strobe when a new result is presented |
| pu_i | output | OUT_W | In-phase of the 2/9 tone (pick-up) |
| pu_q | output | OUT_W | Quadrature of the 2/9 tone (pick-up) |
| fw_i | output | OUT_W | In-phase of the 3/9 tone (forward) |
| fw_q | output | OUT_W | Quadrature of the 3/9 tone (forward) |
| rf_i | output | OUT_W | In-phase of the 4/9 tone (reflection) |
| rf_q | output | OUT_W | Quadrature of the 4/9 tone (reflection) |

## Verification
The assertions assume that `rst` is high on the first clock edge, so that the window counter starts known. They assume that `adc` is a two's-complement value inside the 16-bit range, so that the output-magnitude bound holds. The bench holds reset from time zero. It builds every stimulus from tones whose amplitudes add up to no more than the full-scale code, and it raises `align` only as a single-cycle pulse between test windows.

// File: rtl/multi_if_iq_demod.sv
module multi_if_iq_demod #(
  parameter int DATA_W = 16,
  parameter int OUT_W  = DATA_W + 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     align,
  input  logic signed [DATA_W-1:0] adc,
  output logic                     valid,
  output logic signed [OUT_W-1:0]  pu_i,
  output logic signed [OUT_W-1:0]  pu_q,
  output logic signed [OUT_W-1:0]  fw_i,
  output logic signed [OUT_W-1:0]  fw_q,
  output logic signed [OUT_W-1:0]  rf_i,
  output logic signed [OUT_W-1:0]  rf_q
);
  localparam int PERIOD  = 9;
  localparam int N_IF    = 3;
  localparam int PH_W    = $clog2(PERIOD);
  localparam int COEF_W  = 16;
  localparam int FRAC    = 14;
  localparam int PROD_W  = DATA_W + COEF_W;
  localparam int ACC_W   = PROD_W + PH_W;
  localparam int SCL_FR  = 18;
  localparam int SHIFT   = FRAC + SCL_FR;
  localparam logic signed [SCL_FR:0] SCALE = 19'sd58254;
  localparam int MUL_W   = ACC_W + SCL_FR + 1;

  function automatic logic signed [COEF_W-1:0] cos_lut(input logic [PH_W-1:0] m);
    case (m)
      4'd0: cos_lut = 16'sd16384;
      4'd1, 4'd8: cos_lut = 16'sd12551;
      4'd2, 4'd7: cos_lut = 16'sd2845;
      4'd3, 4'd6: cos_lut = -16'sd8192;
      default: cos_lut = -16'sd15396;
    endcase
  endfunction

  function automatic logic signed [COEF_W-1:0] sin_lut(input logic [PH_W-1:0] m);
    case (m)
      4'd0: sin_lut = 16'sd0;
      4'd1: sin_lut = 16'sd10531;
      4'd2: sin_lut = 16'sd16135;
      4'd3: sin_lut = 16'sd14189;
      4'd4: sin_lut = 16'sd5604;
      4'd5: sin_lut = -16'sd5604;
      4'd6: sin_lut = -16'sd14189;
      4'd7: sin_lut = -16'sd16135;
      default: sin_lut = -16'sd10531;
    endcase
  endfunction

  logic [PH_W-1:0] phase;
  wire first = (phase == '0);
  wire last  = (phase == PH_W'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (rst || align || last) phase <= '0;
    else                      phase <= phase + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) valid <= 1'b0;
    else     valid <= last;
  end

  logic signed [OUT_W-1:0] res_i [N_IF];
  logic signed [OUT_W-1:0] res_q [N_IF];

  for (genvar g = 0; g < N_IF; g++) begin : g_tone
    localparam int K = g + 2;
    logic [PH_W-1:0]          idx;
    logic signed [COEF_W-1:0] c, s;
    logic signed [PROD_W-1:0] prod_i, prod_q;
    logic signed [ACC_W-1:0]  ext_i, ext_q, acc_i, acc_q, sum_i, sum_q;
    logic signed [MUL_W-1:0]  scl_i, scl_q;

    assign idx    = PH_W'((K * int'(phase)) % PERIOD);
    assign c      = cos_lut(idx);
    assign s      = sin_lut(idx);
    assign prod_i = adc * c;
    assign prod_q = adc * s;
    assign ext_i  = prod_i;
    assign ext_q  = prod_q;
    assign sum_i  = (first ? '0 : acc_i) + ext_i;
    assign sum_q  = (first ? '0 : acc_q) - ext_q;
    assign scl_i  = sum_i * SCALE;
    assign scl_q  = sum_q * SCALE;

    always_ff @(posedge clk) begin
      if (rst) begin
        acc_i <= '0;
        acc_q <= '0;
        res_i[g] <= '0;
        res_q[g] <= '0;
      end else begin
        acc_i <= sum_i;
        acc_q <= sum_q;
        if (last) begin
          res_i[g] <= scl_i[SHIFT+OUT_W-1:SHIFT];
          res_q[g] <= scl_q[SHIFT+OUT_W-1:SHIFT];
        end
      end
    end
  end

  assign pu_i = res_i[0];
  assign pu_q = res_q[0];
  assign fw_i = res_i[1];
  assign fw_q = res_q[1];
  assign rf_i = res_i[2];
  assign rf_q = res_q[2];
endmodule

module multi_if_iq_demod_chk #(
  parameter int OUT_W = 18
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    align,
  input logic                    valid,
  input logic [3:0]              phase,
  input logic signed [OUT_W-1:0] pu_i,
  input logic signed [OUT_W-1:0] pu_q,
  input logic signed [OUT_W-1:0] fw_i,
  input logic signed [OUT_W-1:0] fw_q,
  input logic signed [OUT_W-1:0] rf_i,
  input logic signed [OUT_W-1:0] rf_q
);
  localparam logic signed [OUT_W-1:0] LIM = OUT_W'(2 ** (OUT_W - 2));

  // R1
  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> (!valid && pu_i == 0 && rf_q == 0));
  // R2
  a_r2_strobe_after_last: assert property (@(posedge clk) disable iff (rst)
    valid |-> ($past(phase) == 4'd8));
  a_r2_phase_range: assert property (@(posedge clk) disable iff (rst) phase <= 4'd8);
  a_r2_single_cycle: assert property (@(posedge clk) disable iff (rst) valid |=> !valid);
  // R3
  a_r3_align_restart: assert property (@(posedge clk) disable iff (rst) align |=> (phase == 4'd0));
  // R8
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !valid |-> ($stable(pu_i) && $stable(pu_q) && $stable(fw_i) &&
                $stable(fw_q) && $stable(rf_i) && $stable(rf_q)));
  // R9
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (pu_i <= LIM && pu_i >= -LIM && pu_q <= LIM && pu_q >= -LIM &&
     fw_i <= LIM && fw_i >= -LIM && fw_q <= LIM && fw_q >= -LIM &&
     rf_i <= LIM && rf_i >= -LIM && rf_q <= LIM && rf_q >= -LIM));
endmodule

bind multi_if_iq_demod multi_if_iq_demod_chk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .align(align), .valid(valid), .phase(phase),
  .pu_i(pu_i), .pu_q(pu_q), .fw_i(fw_i), .fw_q(fw_q), .rf_i(rf_i), .rf_q(rf_q)
);

// File: tb/tb_multi_if_iq_demod.sv
module tb_multi_if_iq_demod;
  localparam int DATA_W = 16;
  localparam int OUT_W  = 18;
  localparam real PI    = 3.14159265358979;
  localparam int TOL    = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic align = 1'b0;
  logic signed [DATA_W-1:0] adc = '0;
  logic valid;
  logic signed [OUT_W-1:0] pu_i, pu_q, fw_i, fw_q, rf_i, rf_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  multi_if_iq_demod #(.DATA_W(DATA_W), .OUT_W(OUT_W)) dut (
    .clk(clk), .rst(rst), .align(align), .adc(adc), .valid(valid),
    .pu_i(pu_i), .pu_q(pu_q), .fw_i(fw_i), .fw_q(fw_q), .rf_i(rf_i), .rf_q(rf_q)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic near(input string tag, input int act, input real exp);
    int e = $rtoi(exp >= 0.0 ? exp + 0.5 : exp - 0.5);
    check((act - e <= TOL) && (e - act <= TOL), tag, act, e);
  endtask

  function automatic int sample(input int n, input int amp[3], input real ph[3]);
    real v = 0.0;
    for (int k = 0; k < 3; k++)
      v += amp[k] * $cos(2.0 * PI * (k + 2) * n / 9.0 + ph[k] * PI / 180.0);
    return $rtoi(v >= 0.0 ? v + 0.5 : v - 0.5);
  endfunction

  function automatic int out_of(input int k, input bit q);
    case (k)
      0: return q ? int'(pu_q) : int'(pu_i);
      1: return q ? int'(fw_q) : int'(fw_i);
      default: return q ? int'(rf_q) : int'(rf_i);
    endcase
  endfunction

  task automatic run_window(input string tag, input int amp[3], input real ph[3]);
    int  x [9];
    real ei, eq;
    string rq [3];
    rq = '{"R4", "R5", "R6"};
    align = 1'b1;
    @(negedge clk);
    align = 1'b0;
    for (int n = 0; n < 9; n++) begin
      x[n] = sample(n, amp, ph);
      adc = DATA_W'(x[n]);
      if (n == 4) check(valid == 1'b0, {tag, " R2 no strobe mid-window"}, int'(valid), 0);
      @(negedge clk);
    end
    check(valid == 1'b1, {tag, " R3 strobe 9 cycles after align"}, int'(valid), 1);
    for (int k = 0; k < 3; k++) begin
      ei = 0.0;
      eq = 0.0;
      for (int n = 0; n < 9; n++) begin
        ei += x[n] * $cos(2.0 * PI * (k + 2) * n / 9.0);
        eq -= x[n] * $sin(2.0 * PI * (k + 2) * n / 9.0);
      end
      near({tag, " ", rq[k], " I"}, out_of(k, 1'b0), ei * 2.0 / 9.0);
      near({tag, " ", rq[k], " Q"}, out_of(k, 1'b1), eq * 2.0 / 9.0);
    end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check(valid == 1'b0, "R1 valid in reset", int'(valid), 0);
    check(pu_i == 0 && fw_q == 0 && rf_i == 0, "R1 outputs in reset", int'(pu_i), 0);
    rst = 1'b0;
    @(negedge clk);
    check(valid == 1'b0 && rf_q == 0, "R1 first cycle after reset", int'(valid), 0);
  endtask

  task automatic t_single(input int k, input int amp, input real ph);
    int  a [3] = '{0, 0, 0};
    real p [3] = '{0.0, 0.0, 0.0};
    a[k] = amp;
    p[k] = ph;
    run_window($sformatf("tone k=%0d", k + 2), a, p);
    near("R4 pu_i vs A*cos(phi)", out_of(k, 1'b0), amp * $cos(ph * PI / 180.0));
    near("R4/R5/R6 Q vs A*sin(phi)", out_of(k, 1'b1), amp * $sin(ph * PI / 180.0));
    for (int j = 0; j < 3; j++)
      if (j != k) begin
        near("R7 other I near zero", out_of(j, 1'b0), 0.0);
        near("R7 other Q near zero", out_of(j, 1'b1), 0.0);
      end
  endtask

  task automatic t_mix;
    int  a [3] = '{9000, 11000, 7000};
    real p [3] = '{30.0, -120.0, 75.0};
    run_window("R10 mixed", a, p);
    for (int k = 0; k < 3; k++) begin
      near("R10 I separated", out_of(k, 1'b0), a[k] * $cos(p[k] * PI / 180.0));
      near("R10 Q separated", out_of(k, 1'b1), a[k] * $sin(p[k] * PI / 180.0));
    end
  endtask

  task automatic t_fullscale;
    int  a [3] = '{32767, 0, 0};
    real p [3] = '{0.0, 0.0, 0.0};
    run_window("R9 full scale", a, p);
    near("R9 full-scale I no wrap", int'(pu_i), 32767.0);
    a = '{0, 0, 32767};
    p = '{0.0, 0.0, 180.0};
    run_window("R9 full scale neg", a, p);
    near("R9 full-scale negative I", int'(rf_i), -32767.0);
  endtask

  task automatic t_align;
    int  a [3] = '{0, 12000, 0};
    real p [3] = '{0.0, 45.0, 0.0};
    for (int n = 0; n < 5; n++) begin
      adc = 16'sd30000;
      @(negedge clk);
    end
    run_window("R3 align mid-window", a, p);
    near("R3 pre-align samples excluded I", int'(fw_i), 12000.0 * $cos(PI / 4.0));
    near("R3 pre-align samples excluded pu", int'(pu_i), 0.0);
  endtask

  task automatic t_period;
    int cnt = 0;
    int gap = 0;
    int bad = 0;
    int seen = 0;
    adc = 16'sd1000;
    for (int c = 0; c < 45; c++) begin
      @(negedge clk);
      gap++;
      if (valid) begin
        cnt++;
        if (seen != 0 && gap != 9) bad++;
        seen = 1;
        gap = 0;
      end
    end
    check(cnt == 5, "R2 strobes in 45 cycles", cnt, 5);
    check(bad == 0, "R2 strobe spacing 9", bad, 0);
  endtask

  task automatic t_hold;
    int  a [3] = '{5000, 0, 0};
    real p [3] = '{60.0, 0.0, 0.0};
    int  si, sq;
    int  moved = 0;
    run_window("R8 hold base", a, p);
    si = int'(pu_i);
    sq = int'(pu_q);
    for (int n = 0; n < 7; n++) begin
      adc = DATA_W'(-20000 + n * 3000);
      @(negedge clk);
      if (int'(pu_i) != si || int'(pu_q) != sq || valid) moved++;
    end
    check(moved == 0, "R8 outputs hold between strobes", moved, 0);
  endtask

  initial begin
    t_reset();
    t_single(0, 10000, 0.0);
    t_single(0, 8000, 135.0);
    t_single(1, 15000, -60.0);
    t_single(2, 20000, 200.0);
    t_mix();
    t_fullscale();
    t_align();
    t_period();
    t_hold();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule